// File: doc/BRIEF.md
# Oversampling Decimator with Status Flags

The block follows a 12-bit converter. It sums a programmable power-of-two count of raw samples into one output word, then scales the sum to an output width from 12 to 16 bits. The width setting does not depend on the decimation setting. Each new word is held in an output register until a consumer takes it. The consumer is a processor read strobe or a DMA acknowledge.

There are three sticky status flags. The ready flag is set for every new word. The sequence flag is set when the word's group held the sample that ended a conversion sequence; the ready flag is set with it. The overrun flag is set when a word arrives while the held word has not been consumed. Software clears a flag by writing 1 to its bit. A policy bit chooses which word survives an overrun. An interrupt line combines the enabled flags. In DMA mode each held word raises a DMA request, and the ready flag is removed from the interrupt.

Configuration inputs must stay stable while a group is being accumulated.

Top module: `sdec_top`

## Requirements
- R1: After reset, `dout`, all three flags, `irq` and `dma_req` are 0.
- R2: One output word is produced for every 2^`cfg_ratio` samples that have `raw_valid` high. `cfg_ratio` = 0 means one word per sample, and the largest code, 7, means 128 samples per word. Cycles with `raw_valid` low change neither the sample count nor the sum.
- R3: The word equals S·2^W / 2^(12+`cfg_ratio`), rounded toward zero. S is the sum of the group and W = 12 + `cfg_width`. Codes 0 to 4 give widths 12 to 16, and codes 5 to 7 are treated as 16. The word is right-aligned in `dout` and the unused high bits are 0.
- R4: `flag_rdy` is set in the cycle after each word is produced. Bit 0 of `clr_w1c` clears it. When a set and a clear happen in the same cycle, the set wins.
- R5: `flag_seq` is set, together with `flag_rdy`, when the word's group included a sample that had `seq_end` high. Bit 1 of `clr_w1c` clears it.
- R6: `flag_ovr` is set when a word is produced while a held word is still pending and no consumption happens in that cycle. Bit 2 of `clr_w1c` clears it.
- R7: On an overrun, `cfg_keep_old` = 0 replaces the held word with the new one, and `cfg_keep_old` = 1 leaves `dout` unchanged.
- R8: A pulse on `rd_strobe` or `dma_ack` consumes the held word. If consumption and production happen in the same cycle, this is not an overrun and the new word is loaded.
- R9: `irq` is the OR of each flag ANDed with its enable. The enable bits are: bit 0 ready, bit 1 sequence, bit 2 overrun. When `cfg_dma_mode` = 1, the ready flag does not drive `irq`.
- R10: `dma_req` is high when `cfg_dma_mode` = 1 and a word is pending. It falls in the cycle after the word is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_valid | input | 1 | Raw sample strobe |
| raw_data | input | 12 | Raw converter sample |
| seq_end | input | 1 | Marks the last sample of a conversion sequence |
| cfg_ratio | input | 3 | log2 of the decimation ratio |
| cfg_width | input | 3 | Output width minus 12 |
| cfg_keep_old | input | 1 | Overrun policy: 1 keeps the held word |
| cfg_dma_mode | input | 1 | Send each word to a DMA request |
| irq_en | input | 3 | Interrupt enables {ovr, seq, rdy} |
| clr_w1c | input | 3 | Write-1-to-clear strobes {ovr, seq, rdy} |
| rd_strobe | input | 1 | Processor read of the output word |
| dma_ack | input | 1 | DMA acknowledge of the output word |
| dout | output | 16 | Held output word |
| flag_rdy | output | 1 | End-of-decimation flag |
| flag_seq | output | 1 | End-of-sequence flag |
| flag_ovr | output | 1 | Overrun flag |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 1 | DMA request |

## Verification
The bench drives the scaling extremes:
- a left shift (ratio 3 at 16 bits, with all-ones samples),
- a deep right shift (ratio 7 at 12 bits, with idle gaps),
- an illegal width code.

A wrong shift direction, or a count that advances on idle cycles, shows up as a wrong word or a word at the wrong time.

The bench produces a word in the same cycle as a consume and in the same cycle as a ready-clear. A design that gives the clear priority, or that treats a consume in the production cycle as an overrun, then reports a false flag. Both overrun policies are tested, along with the DMA mode masking of the ready flag. A swapped policy, or a request that stays high after the acknowledge, changes `dout` or `dma_req` where the bench expects otherwise.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
  // Flag bit positions; clr_w1c and irq_en use the same positions.
  localparam int unsigned FLG_RDY = 0;
  localparam int unsigned FLG_SEQ = 1;
  localparam int unsigned FLG_OVR = 2;
  localparam int unsigned NUM_FLG = 3;

  // Align a sum of in_bits significant bits to out_bits.
  // A right shift rounds toward zero.
  function automatic logic [31:0] sdec_scale(input logic [31:0] s,
                                             input int unsigned in_bits,
                                             input int unsigned out_bits);
    if (in_bits >= out_bits) return s >> (in_bits - out_bits);
    else                     return s << (out_bits - in_bits);
  endfunction
endpackage

// File: rtl/sdec_accum.sv
module sdec_accum #(
  parameter int unsigned RAW_W   = 12,
  parameter int unsigned RLOG_MX = 7,
  parameter int unsigned RCODE_W = 3,
  parameter int unsigned ACC_W   = RAW_W + RLOG_MX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raw_valid,
  input  logic [RAW_W-1:0]   raw_data,
  input  logic               seq_end,
  input  logic [RCODE_W-1:0] ratio,
  output logic               prod_o,
  output logic [ACC_W-1:0]   sum_o,
  output logic               seq_o
);
  localparam int unsigned CNT_W = (RLOG_MX > 0) ? RLOG_MX : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;
  logic             seq_q;
  logic [CNT_W-1:0] last_idx;

  // Index of the last sample in a group: 2^ratio - 1.
  assign last_idx = CNT_W'(({CNT_W{1'b1}}) >> (CNT_W - int'(ratio)));
  assign prod_o   = raw_valid && (cnt_q >= last_idx);
  assign sum_o    = acc_q + ACC_W'(raw_data);
  assign seq_o    = seq_q | seq_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      seq_q <= 1'b0;
    end else if (raw_valid) begin
      if (prod_o) begin
        cnt_q <= '0;
        acc_q <= '0;
        seq_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= sum_o;
        seq_q <= seq_o;
      end
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_valid |=> ($stable(cnt_q) && $stable(acc_q)));
endmodule

// File: rtl/sdec_hold.sv
module sdec_hold #(
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prod,
  input  logic [OUT_W-1:0] word,
  input  logic             keep_old,
  input  logic             consume,
  input  logic             dma_mode,
  output logic [OUT_W-1:0] dout,
  output logic             ovr_evt,
  output logic             dma_req
);
  logic [OUT_W-1:0] dout_q;
  logic             pend_q;
  logic             load;

  assign ovr_evt = prod && pend_q && !consume;
  assign load    = prod && !(ovr_evt && keep_old);
  assign dout    = dout_q;
  assign dma_req = dma_mode && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (load) dout_q <= word;
      if (prod)         pend_q <= 1'b1;
      else if (consume) pend_q <= 1'b0;
    end
  end

  assert_keep_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && keep_old) |=> $stable(dout_q));
  assert_new_loaded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prod && consume) |=> (pend_q && dout_q == $past(word)));
  assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !prod) |=> !dma_req);
endmodule

// File: rtl/sdec_flags.sv
module sdec_flags
  import sdec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_FLG-1:0] set_i,
  input  logic [NUM_FLG-1:0] clr_i,
  input  logic [NUM_FLG-1:0] en_i,
  input  logic               dma_mode,
  output logic [NUM_FLG-1:0] flag_o,
  output logic               irq_o
);
  logic [NUM_FLG-1:0] flag_q;
  logic [NUM_FLG-1:0] mask;

  for (genvar g = 0; g < NUM_FLG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= set_i[g] | (flag_q[g] & ~clr_i[g]);
    end
  end

  always_comb begin
    mask          = '1;
    mask[FLG_RDY] = ~dma_mode;
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i & mask);

  assert_rdy_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[FLG_RDY] |=> flag_q[FLG_RDY]);
  assert_rdy_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[FLG_RDY] && !set_i[FLG_RDY]) |=> !flag_q[FLG_RDY]);
  assert_seq_with_rdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[FLG_SEQ] |=> (flag_q[FLG_SEQ] && flag_q[FLG_RDY]));
  assert_ovr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[FLG_OVR] |=> flag_q[FLG_OVR]);
endmodule

// File: rtl/sdec_top.sv
module sdec_top
  import sdec_pkg::*;
#(
  parameter int unsigned RAW_W     = 12,
  parameter int unsigned RLOG_MX   = 7,
  parameter int unsigned OUT_MAX_W = 16,
  parameter int unsigned RCODE_W   = 3,
  parameter int unsigned WCODE_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 raw_valid,
  input  logic [RAW_W-1:0]     raw_data,
  input  logic                 seq_end,
  input  logic [RCODE_W-1:0]   cfg_ratio,
  input  logic [WCODE_W-1:0]   cfg_width,
  input  logic                 cfg_keep_old,
  input  logic                 cfg_dma_mode,
  input  logic [2:0]           irq_en,
  input  logic [2:0]           clr_w1c,
  input  logic                 rd_strobe,
  input  logic                 dma_ack,
  output logic [OUT_MAX_W-1:0] dout,
  output logic                 flag_rdy,
  output logic                 flag_seq,
  output logic                 flag_ovr,
  output logic                 irq,
  output logic                 dma_req
);
  localparam int unsigned ACC_W     = RAW_W + RLOG_MX;
  localparam int unsigned MAX_WCODE = OUT_MAX_W - RAW_W;

  logic               prod;
  logic               seq_hit;
  logic [ACC_W-1:0]   sum;
  logic [OUT_MAX_W-1:0] word;
  logic               ovr_evt;
  logic [NUM_FLG-1:0] set_v;
  logic [NUM_FLG-1:0] flags;
  int unsigned        in_bits;
  int unsigned        out_bits;

  sdec_accum #(.RAW_W(RAW_W), .RLOG_MX(RLOG_MX), .RCODE_W(RCODE_W), .ACC_W(ACC_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_data(raw_data),
    .seq_end(seq_end), .ratio(cfg_ratio), .prod_o(prod), .sum_o(sum), .seq_o(seq_hit)
  );

  always_comb begin
    in_bits  = RAW_W + int'(cfg_ratio);
    out_bits = (int'(cfg_width) > MAX_WCODE) ? OUT_MAX_W : RAW_W + int'(cfg_width);
    word     = OUT_MAX_W'(sdec_scale(32'(sum), in_bits, out_bits));
  end

  sdec_hold #(.OUT_W(OUT_MAX_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .prod(prod), .word(word), .keep_old(cfg_keep_old),
    .consume(rd_strobe | dma_ack), .dma_mode(cfg_dma_mode), .dout(dout),
    .ovr_evt(ovr_evt), .dma_req(dma_req)
  );

  always_comb begin
    set_v          = '0;
    set_v[FLG_RDY] = prod;
    set_v[FLG_SEQ] = prod & seq_hit;
    set_v[FLG_OVR] = ovr_evt;
  end

  sdec_flags flags_i (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_w1c), .en_i(irq_en),
    .dma_mode(cfg_dma_mode), .flag_o(flags), .irq_o(irq)
  );

  assign flag_rdy = flags[FLG_RDY];
  assign flag_seq = flags[FLG_SEQ];
  assign flag_ovr = flags[FLG_OVR];
endmodule

// File: tb/sdec_top_tb.sv
`timescale 1ns/1ps
module sdec_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raw_valid = 1'b0;
  logic [11:0] raw_data = '0;
  logic        seq_end = 1'b0;
  logic [2:0]  cfg_ratio = '0;
  logic [2:0]  cfg_width = '0;
  logic        cfg_keep_old = 1'b0;
  logic        cfg_dma_mode = 1'b0;
  logic [2:0]  irq_en = '0;
  logic [2:0]  clr_w1c = '0;
  logic        rd_strobe = 1'b0;
  logic        dma_ack = 1'b0;
  logic [15:0] dout;
  logic        flag_rdy, flag_seq, flag_ovr, irq, dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdec_top dut_i (
    .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_data(raw_data),
    .seq_end(seq_end), .cfg_ratio(cfg_ratio), .cfg_width(cfg_width),
    .cfg_keep_old(cfg_keep_old), .cfg_dma_mode(cfg_dma_mode), .irq_en(irq_en),
    .clr_w1c(clr_w1c), .rd_strobe(rd_strobe), .dma_ack(dma_ack), .dout(dout),
    .flag_rdy(flag_rdy), .flag_seq(flag_seq), .flag_ovr(flag_ovr), .irq(irq),
    .dma_req(dma_req)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected word: scale by multiply then divide (rounds toward zero).
  function automatic longint exp_word(input longint s, input int r, input int wc);
    int w;
    w = (wc > 4) ? 16 : 12 + wc;
    return (s * (longint'(1) << w)) / (longint'(1) << (12 + r));
  endfunction

  // One clock of stimulus; outputs are readable when the task returns.
  task automatic step(input logic v, input logic [11:0] d, input logic s,
                      input logic [2:0] c, input logic r, input logic a);
    @(negedge clk);
    raw_valid = v; raw_data = d; seq_end = s; clr_w1c = c; rd_strobe = r; dma_ack = a;
    @(posedge clk); #1;
    raw_valid = 0; seq_end = 0; clr_w1c = 0; rd_strobe = 0; dma_ack = 0;
  endtask

  task automatic smp(input logic [11:0] d);
    step(1, d, 0, 3'b000, 0, 0);
  endtask

  task automatic tidy();
    step(0, 0, 0, 3'b111, 1, 0);
  endtask

  task automatic t_reset();
    chk("R1 dout", dout, 0);
    chk("R1 flags", {flag_rdy, flag_seq, flag_ovr}, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma_req", dma_req, 0);
  endtask

  task automatic t_passthru();
    cfg_ratio = 0; cfg_width = 0; tidy();
    smp(12'hABC);
    chk("R2 ratio0 rdy", flag_rdy, 1);
    chk("R3 ratio0 word", dout, 16'h0ABC);
  endtask

  task automatic t_scale_up();
    longint s = 0;
    cfg_ratio = 3; cfg_width = 4; tidy();
    for (int i = 0; i < 7; i++) begin smp(12'hFFF); s += 12'hFFF; end
    chk("R2 no word before 8th sample", flag_rdy, 0);
    smp(12'hFFF); s += 12'hFFF;
    chk("R2 word at 8th sample", flag_rdy, 1);
    chk("R3 left shift word", dout, exp_word(s, 3, 4));
  endtask

  task automatic t_ratio7();
    longint s = 0;
    cfg_ratio = 7; cfg_width = 0; tidy();
    for (int i = 0; i < 128; i++) begin
      logic [11:0] d;
      d = 12'((i * 37 + 5) & 12'hFFF);
      if (i % 5 == 0) step(0, 12'hFFF, 0, 3'b000, 0, 0);
      if (i == 127) chk("R2 gaps not counted", flag_rdy, 0);
      smp(d); s += d;
    end
    chk("R2 ratio7 word ready", flag_rdy, 1);
    chk("R3 ratio7 right shift", dout, exp_word(s, 7, 0));
  endtask

  task automatic t_width_illegal();
    cfg_ratio = 1; cfg_width = 6; tidy();
    smp(12'h800); smp(12'h801);
    chk("R3 width code 6 as 16", dout, exp_word(12'h800 + 12'h801, 1, 6));
  endtask

  task automatic t_seq();
    cfg_ratio = 2; cfg_width = 0; tidy();
    smp(12'h010);
    step(1, 12'h020, 1, 3'b000, 0, 0);
    chk("R5 seq not yet", flag_seq, 0);
    smp(12'h030); smp(12'h040);
    chk("R5 seq flag", flag_seq, 1);
    chk("R5 seq also rdy", flag_rdy, 1);
    step(0, 0, 0, 3'b010, 0, 0);
    chk("R5 seq w1c", flag_seq, 0);
    chk("R5 rdy kept", flag_rdy, 1);
    step(0, 0, 0, 3'b001, 0, 0);
    chk("R4 rdy w1c", flag_rdy, 0);
    smp(1); smp(2); smp(3);
    step(1, 12'h004, 0, 3'b001, 1, 0);
    chk("R4 set wins over clear", flag_rdy, 1);
  endtask

  task automatic t_overrun();
    cfg_ratio = 0; cfg_width = 0; cfg_keep_old = 0; tidy();
    smp(12'h111); smp(12'h222);
    chk("R6 overrun set", flag_ovr, 1);
    chk("R7 keep new", dout, 16'h0222);
    step(0, 0, 0, 3'b100, 0, 0);
    chk("R6 ovr w1c", flag_ovr, 0);
    tidy();
    cfg_keep_old = 1;
    smp(12'h333); smp(12'h444);
    chk("R6 overrun set again", flag_ovr, 1);
    chk("R7 keep old", dout, 16'h0333);
    tidy();
    smp(12'h555);
    step(1, 12'h666, 0, 3'b000, 1, 0);
    chk("R8 consume same cycle no ovr", flag_ovr, 0);
    chk("R8 new word loaded", dout, 16'h0666);
    tidy();
    smp(12'h777);
    chk("R8 after read no ovr", flag_ovr, 0);
    cfg_keep_old = 0;
  endtask

  task automatic t_irq();
    cfg_ratio = 0; cfg_width = 0; tidy();
    irq_en = 3'b100;
    smp(1); smp(2);
    chk("R9 ovr irq", irq, 1);
    irq_en = 3'b000; #1;
    chk("R9 masked", irq, 0);
    irq_en = 3'b001; #1;
    chk("R9 rdy irq", irq, 1);
    tidy();
    chk("R9 cleared", irq, 0);
  endtask

  task automatic t_dma();
    cfg_ratio = 0; cfg_width = 0; cfg_dma_mode = 1; irq_en = 3'b001; tidy();
    chk("R10 idle no req", dma_req, 0);
    smp(12'h0AA);
    chk("R10 req on word", dma_req, 1);
    chk("R9 rdy set in dma mode", flag_rdy, 1);
    chk("R9 rdy masked in dma mode", irq, 0);
    step(0, 0, 0, 3'b000, 0, 1);
    chk("R10 req drops after ack", dma_req, 0);
    smp(12'h0BB);
    step(1, 12'h0CC, 0, 3'b000, 0, 1);
    chk("R8 ack same cycle no ovr", flag_ovr, 0);
    chk("R10 req held for new", dma_req, 1);
    cfg_dma_mode = 0; irq_en = 0; tidy();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    rst_n = 1'b1;
    t_passthru();
    t_scale_up();
    t_ratio7();
    t_width_illegal();
    t_seq();
    t_overrun();
    t_irq();
    t_dma();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule